// File: doc/BRIEF.md
# Pipeline Data Hazard Interlock

This block is the interlock for a five-stage in-order pipeline: fetch, decode with operand read, ALU, memory access and register write-back. Each cycle it looks at the instruction word in the decode stage. It compares that word's two source register fields against the destination field of every older instruction still in the ALU, memory and write-back stages. No forwarding exists, so a consumer must wait until its producer has left write-back. The interlock enforces that wait by stalling the front of the pipeline and feeding no-operation bubbles into the ALU stage.

The block keeps its own small shadow of the opcode and destination field for stages 3 to 5. These registers advance every cycle, in step with the datapath pipeline registers. On a stall the shadow loads a bubble (opcode 0), just as the datapath does. A small opcode-class decoder sorts each opcode into one of three classes: no-operation, register-writing ALU operation, or other. Only ALU-class pairs are compared.

`pause` is combinational from the decode word and the shadow registers. The datapath uses it to hold its fetch and decode registers. `bubble` tells the datapath to load a no-operation into the ALU-stage register on the same edge.

Top module: `hz_stall_unit`

## Requirements
- R1: The decode word is split as opcode = bits 31:27, destination = bits 26:22, first source = bits 21:17, second source = bits 16:12; bits 11:0 never affect `pause`.
- R2: Opcodes from ALU_OP_LO to ALU_OP_HI inclusive (12 to 27 by default) are ALU-class and write a register. Opcode 0 is the no-operation. Every other opcode is neither.
- R3: `pause` is high when the decode instruction and the stage-3 instruction are both ALU-class and the stage-3 destination equals the decode first or second source.
- R4: The same comparison raises `pause` against the stage-4 instruction.
- R5: The same comparison raises `pause` against the stage-5 instruction, because its write has not yet landed.
- R6: `pause` stays low when the consumer in decode is not ALU-class, or when the older instruction is a no-operation or is not ALU-class, even if the register fields match.
- R7: On every cycle with `pause` high, stage 3 receives a no-operation, and the held decode instruction is re-examined next cycle. As a result, a matching ALU pair that is 1, 2 or 3 instructions apart stalls for exactly 3, 2 or 1 cycles. A pair 4 or more apart does not stall.
- R8: `pause` is combinational: it rises in the same cycle that a dependent word reaches decode, and it falls in the cycle after the producer leaves stage 5.
- R9: Reset (active-low, asynchronous) clears stages 3 to 5 to no-operations. Directly after reset, no decode word causes `pause`.
- R10: `bubble` is high in exactly the cycles where `pause` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_ir | input | IR_W (32) | Instruction word in the decode stage |
| pause | output | 1 | Hold fetch and decode registers this cycle |
| bubble | output | 1 | Load a no-operation into the ALU-stage register |

## Verification
The bench uses the default build: 32-bit words, 5-bit opcode and register fields, ALU opcodes 12 to 27, and a three-stage comparison window. With 5-bit fields, every opcode pair (1024 combinations) and every destination-versus-source register pair on both source fields can be swept in full. Producer-to-consumer distances from 1 to 5 are also swept, covering the exact stall lengths and the point where the window ends. A long pseudo-random stream drawn from only four registers then creates dense chains of back-to-back and overlapping dependencies. Each cycle of that stream is compared against an arithmetic model of the pipeline.

// File: rtl/hz_pkg.sv
package hz_pkg;

    parameter int HZ_OP_W  = 5;
    parameter int HZ_REG_W = 5;

    typedef enum logic [1:0] {
        CLS_NOP   = 2'd0,
        CLS_ALU   = 2'd1,
        CLS_OTHER = 2'd2
    } hz_cls_e;

    typedef struct packed {
        logic [HZ_OP_W-1:0]  op;
        logic [HZ_REG_W-1:0] ra;
    } hz_dest_t;

endpackage

// File: rtl/hz_opclass.sv
module hz_opclass
    import hz_pkg::*;
#(
    parameter int ALU_OP_LO = 12,
    parameter int ALU_OP_HI = 27,
    parameter int NOP_OP    = 0
) (
    input  logic [HZ_OP_W-1:0] op,
    output hz_cls_e            cls
);

    always_comb begin
        if (int'(op) == NOP_OP)
            cls = CLS_NOP;
        else if (int'(op) >= ALU_OP_LO && int'(op) <= ALU_OP_HI)
            cls = CLS_ALU;
        else
            cls = CLS_OTHER;
    end

endmodule

// File: rtl/hz_pair_cmp.sv
module hz_pair_cmp
    import hz_pkg::*;
(
    input  hz_cls_e             cons_cls,
    input  logic [HZ_REG_W-1:0] cons_rb,
    input  logic [HZ_REG_W-1:0] cons_rc,
    input  hz_cls_e             prod_cls,
    input  logic [HZ_REG_W-1:0] prod_ra,
    output logic                hit
);

    logic both_alu;
    logic reg_match;

    always_comb begin
        both_alu  = (cons_cls == CLS_ALU) && (prod_cls == CLS_ALU);
        reg_match = (prod_ra == cons_rb) || (prod_ra == cons_rc);
        hit       = both_alu && reg_match;
    end

endmodule

// File: rtl/hz_shadow_pipe.sv
module hz_shadow_pipe
    import hz_pkg::*;
#(
    parameter int DEPTH  = 3,
    parameter int NOP_OP = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_nop,
    input  hz_dest_t             in_dest,
    output hz_dest_t [DEPTH-1:0] stage_q
);

    localparam hz_dest_t NOP_DEST = '{op: HZ_OP_W'(NOP_OP), ra: '0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stage_q[0] <= NOP_DEST;
        else if (load_nop)
            stage_q[0] <= NOP_DEST;
        else
            stage_q[0] <= in_dest;
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stage_q[k] <= NOP_DEST;
            else
                stage_q[k] <= stage_q[k-1];
        end
    end

endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
    import hz_pkg::*;
#(
    parameter int IR_W      = 32,
    parameter int ALU_OP_LO = 12,
    parameter int ALU_OP_HI = 27,
    parameter int NOP_OP    = 0,
    parameter int DEPTH     = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IR_W-1:0] dec_ir,
    output logic            pause,
    output logic            bubble
);

    localparam int OP_LSB = IR_W - HZ_OP_W;
    localparam int RA_LSB = OP_LSB - HZ_REG_W;
    localparam int RB_LSB = RA_LSB - HZ_REG_W;
    localparam int RC_LSB = RB_LSB - HZ_REG_W;

    logic [HZ_OP_W-1:0]   dec_op;
    logic [HZ_REG_W-1:0]  dec_ra;
    logic [HZ_REG_W-1:0]  dec_rb;
    logic [HZ_REG_W-1:0]  dec_rc;
    hz_cls_e              dec_cls;
    hz_dest_t             dec_dest;
    hz_dest_t [DEPTH-1:0] stage_q;
    logic [DEPTH-1:0]     hit;
    logic                 unused_lsbs;

    assign dec_op      = dec_ir[OP_LSB +: HZ_OP_W];
    assign dec_ra      = dec_ir[RA_LSB +: HZ_REG_W];
    assign dec_rb      = dec_ir[RB_LSB +: HZ_REG_W];
    assign dec_rc      = dec_ir[RC_LSB +: HZ_REG_W];
    assign dec_dest    = '{op: dec_op, ra: dec_ra};
    assign unused_lsbs = ^dec_ir[RC_LSB-1:0];

    hz_opclass #(
        .ALU_OP_LO(ALU_OP_LO),
        .ALU_OP_HI(ALU_OP_HI),
        .NOP_OP   (NOP_OP)
    ) u_dec_cls (
        .op (dec_op),
        .cls(dec_cls)
    );

    hz_shadow_pipe #(
        .DEPTH (DEPTH),
        .NOP_OP(NOP_OP)
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_nop(pause),
        .in_dest (dec_dest),
        .stage_q (stage_q)
    );

    for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
        hz_cls_e prod_cls;

        hz_opclass #(
            .ALU_OP_LO(ALU_OP_LO),
            .ALU_OP_HI(ALU_OP_HI),
            .NOP_OP   (NOP_OP)
        ) u_prod_cls (
            .op (stage_q[k].op),
            .cls(prod_cls)
        );

        hz_pair_cmp u_cmp (
            .cons_cls(dec_cls),
            .cons_rb (dec_rb),
            .cons_rc (dec_rc),
            .prod_cls(prod_cls),
            .prod_ra (stage_q[k].ra),
            .hit     (hit[k])
        );
    end

    assign pause  = |hit;
    assign bubble = pause;

endmodule

// File: rtl/hz_stall_unit_chk.sv
module hz_stall_unit_chk
    import hz_pkg::*;
#(
    parameter int IR_W      = 32,
    parameter int ALU_OP_LO = 12,
    parameter int ALU_OP_HI = 27,
    parameter int NOP_OP    = 0,
    parameter int DEPTH     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [IR_W-1:0]      dec_ir,
    input logic                 pause,
    input hz_dest_t [DEPTH-1:0] stage_q
);

    localparam int OP_LSB = IR_W - HZ_OP_W;
    localparam int RA_LSB = OP_LSB - HZ_REG_W;
    localparam int RUN_W  = $clog2(DEPTH + 2);

    logic [HZ_OP_W-1:0]  c_op;
    logic [HZ_REG_W-1:0] c_ra;
    logic                c_alu;
    logic [RUN_W-1:0]    run;
    logic                unused_chk;

    assign c_op       = dec_ir[OP_LSB +: HZ_OP_W];
    assign c_ra       = dec_ir[RA_LSB +: HZ_REG_W];
    assign c_alu      = int'(c_op) >= ALU_OP_LO && int'(c_op) <= ALU_OP_HI;
    assign unused_chk = ^dec_ir[RA_LSB-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run <= '0;
        else if (!pause)
            run <= '0;
        else if (run != {RUN_W{1'b1}})
            run <= run + 1'b1;
    end

    a_r6_nonalu_consumer_runs: assert property (@(posedge clk) disable iff (!rst_n)
        !c_alu |-> !pause);

    a_r7_stall_loads_nop: assert property (@(posedge clk) disable iff (!rst_n)
        pause |=> stage_q[0].op == HZ_OP_W'(NOP_OP));

    a_r7_issue_enters_alu: assert property (@(posedge clk) disable iff (!rst_n)
        !pause |=> (stage_q[0].op == $past(c_op)) && (stage_q[0].ra == $past(c_ra)));

    a_r8_stall_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pause |-> int'(run) < DEPTH);

    for (genvar k = 1; k < DEPTH; k++) begin : g_shift
        a_r5_shadow_advances: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> stage_q[k] == $past(stage_q[k-1]));
    end

endmodule

bind hz_stall_unit hz_stall_unit_chk #(
    .IR_W     (IR_W),
    .ALU_OP_LO(ALU_OP_LO),
    .ALU_OP_HI(ALU_OP_HI),
    .NOP_OP   (NOP_OP),
    .DEPTH    (DEPTH)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .dec_ir (dec_ir),
    .pause  (pause),
    .stage_q(stage_q)
);

// File: tb/hz_stall_unit_test.sv
`timescale 1ns/100ps
module hz_stall_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dec_ir = 32'h0;
    logic        pause;
    logic        bubble;

    int vectors = 0;
    int fails   = 0;

    logic [31:0] m3 = 32'h0;
    logic [31:0] m4 = 32'h0;
    logic [31:0] m5 = 32'h0;

    always #2.5 clk = ~clk;

    hz_stall_unit uut (
        .clk   (clk),
        .rst_n (rst_n),
        .dec_ir(dec_ir),
        .pause (pause),
        .bubble(bubble)
    );

    // R1 field layout, low 12 bits filled with junk that must not matter
    function automatic logic [31:0] mk(input int op, input int ra, input int rb, input int rc);
        return {op[4:0], ra[4:0], rb[4:0], rc[4:0], 12'hA5C};
    endfunction

    // R2: ALU class is opcodes 12..27
    function automatic logic is_alu(input logic [4:0] op);
        return (int'(op) >= 12) && (int'(op) <= 27);
    endfunction

    function automatic logic dep(input logic [31:0] c, input logic [31:0] p);
        return is_alu(c[31:27]) && is_alu(p[31:27]) &&
               ((p[26:22] == c[21:17]) || (p[26:22] == c[16:12]));
    endfunction

    task automatic chk_bit(input logic act, input logic exp, input string req);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string req);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: stall cycles got %0d expected %0d", req, act, exp);
        end
    endtask

    // Present a word in decode, hold it while pause is high (R8 per cycle, R10 bubble)
    task automatic issue(input logic [31:0] w, input string req, output int stalls);
        logic e;
        stalls = 0;
        dec_ir = w;
        forever begin
            @(negedge clk);
            e = dep(w, m3) | dep(w, m4) | dep(w, m5);
            chk_bit(pause, e, req);
            chk_bit(bubble, e, "R10");
            @(posedge clk);
            m5 = m4;
            m4 = m3;
            m3 = e ? 32'h0 : w;  // R7: stall puts a nop into stage 3
            #1;
            if (!e) break;
            stalls++;
        end
    endtask

    task automatic flush();
        int s;
        for (int i = 0; i < 3; i++) issue(mk(0, 0, 0, 0), "R6", s);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1 rst_n = 1'b0;
        @(negedge clk);
        chk_bit(pause, 1'b0, "R9");
        @(posedge clk);
        m3 = 32'h0; m4 = 32'h0; m5 = 32'h0;
        #1 rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8: watchdog expired, got running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int s;
        logic [15:0] lfsr;

        // R9: reset state
        dec_ir = mk(20, 1, 1, 1);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk_bit(pause, 1'b0, "R9");
        chk_bit(bubble, 1'b0, "R9");
        @(posedge clk);
        #1;

        // R9: reset discards an in-flight producer
        issue(mk(20, 7, 0, 0), "R9", s);
        do_reset();
        issue(mk(21, 1, 7, 7), "R9", s);
        chk_int(s, 0, "R9");

        // R2 R3 R6: every opcode pair, matching registers
        for (int p = 0; p < 32; p++) begin
            for (int c = 0; c < 32; c++) begin
                flush();
                issue(mk(p, 5, 1, 2), "R6", s);
                issue(mk(c, 9, 5, 3), "R3", s);
                chk_int(s, (is_alu(p[4:0]) && is_alu(c[4:0])) ? 3 : 0, "R2");
            end
        end

        // R3 R4 R5 R7: distance sweep with both source fields and no match
        for (int d = 1; d <= 5; d++) begin
            for (int kind = 0; kind < 3; kind++) begin
                string tag;
                tag = (d == 1) ? "R3" : (d == 2) ? "R4" : (d == 3) ? "R5" : "R7";
                flush();
                issue(mk(20, 11, 30, 31), tag, s);
                for (int f = 1; f < d; f++) issue(mk(13, 20 + f, 30, 31), tag, s);
                issue(mk(14, 2, (kind == 0) ? 11 : 1, (kind == 1) ? 11 : 2), tag, s);
                chk_int(s, (kind < 2 && d <= 3) ? 4 - d : 0, "R7");
            end
        end

        // R1: every destination against every first and second source value
        for (int kind = 0; kind < 2; kind++) begin
            for (int a = 0; a < 32; a++) begin
                for (int b = 0; b < 32; b++) begin
                    int other;
                    other = (a + 1) % 32;
                    flush();
                    issue(mk(12, a, 0, 0), "R1", s);
                    if (kind == 0) issue(mk(27, 3, b, other), "R1", s);
                    else           issue(mk(27, 3, other, b), "R1", s);
                    chk_int(s, (a == b) ? 3 : 0, "R1");
                end
            end
        end

        // R8: dense pseudo-random stream over four registers
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue(mk(int'(lfsr[4:0]), int'(lfsr[6:5]), int'(lfsr[8:7]), int'(lfsr[10:9])),
                  "R8", s);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule